// File: doc/BRIEF.md
# Address-Striped Burst Splitter

This block takes one memory transaction at a time and cuts it into fixed-size bursts for a memory controller with several pseudo-channels. A transaction gives a base byte address, a byte length, a direction flag, a tag, and a second length that is used only when a read command carries no data bytes of its own. Burst `i` is addressed at `base + i * BURST_BYTES`. The number of bursts is the effective length divided by the burst size, rounded up.

Each burst carries a pseudo-channel index taken from the address bits just above the burst offset. Equal addresses therefore always map to the same channel, and strided streams spread over the channels in a fixed pattern. Bursts leave on a valid/ready stream with the direction, the transaction tag and a final-burst marker. The next transaction can be accepted in the same cycle in which the last burst of the current one is handed off.

Top module: `burst_splitter`

## Requirements
- R1: After a synchronous active-low reset, `req_ready` is 1 and `bst_valid` is 0, including when the reset cuts a transaction short.
- R2: A transaction with effective length L gives exactly ceil(L / BURST_BYTES) bursts. `bst_last` is 1 only on the final burst. After that burst is taken, `bst_valid` drops unless a new transaction was accepted.
- R3: Bursts leave in increasing order, at `bst_addr = base + i * BURST_BYTES` modulo 2^ADDR_W, with i counting from 0. The base need not be aligned.
- R4: `bst_ch = (bst_addr >> log2(BURST_BYTES)) & (NUM_CH - 1)`; with the defaults (256-byte bursts, 8 channels) this is `bst_addr[10:8]`. Both parameters must be positive powers of two, and elaboration fails otherwise.
- R5: A transaction whose effective length is 0 is accepted and produces no burst.
- R6: The effective length is `req_len`, except for a read (`req_write` = 0) with `req_len` = 0, which uses `req_cmd_len`. A write never uses `req_cmd_len`, and a read with nonzero `req_len` ignores it.
- R7: Every burst carries the direction (`bst_write`, 1 = write) and `req_tag` of its transaction.
- R8: While `bst_valid` is 1 and `bst_ready` is 0, every burst output holds its value.
- R9: `req_ready` is 0 while bursts of the current transaction remain. The exception is the cycle in which the final burst is taken: `req_ready` is then 1, and an accepted transaction presents its first burst in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Transaction offered |
| req_ready | output | 1 | Transaction can be accepted |
| req_addr | input | ADDR_W | Base byte address |
| req_len | input | LEN_W | Byte length |
| req_write | input | 1 | 1 = write, 0 = read |
| req_cmd_len | input | LEN_W | Length used by a zero-byte read |
| req_tag | input | TAG_W | Transaction tag |
| bst_valid | output | 1 | Burst command valid |
| bst_ready | input | 1 | Burst command taken |
| bst_addr | output | ADDR_W | Burst byte address |
| bst_ch | output | CH_W | Pseudo-channel index |
| bst_write | output | 1 | Burst direction |
| bst_tag | output | TAG_W | Tag of owning transaction |
| bst_last | output | 1 | Final burst of the transaction |

## Verification
Two events can fall in the same cycle: the handoff of a transaction's final burst and the acceptance of the next transaction. The bench provokes this by offering a new request in exactly the cycle the final burst of a two-burst transaction is presented, with `bst_ready` high. It judges the result by seeing `req_ready` high in that cycle and the new transaction's first burst, with its own address, channel and tag, one cycle later. The earlier cycle of the same transaction confirms that `req_ready` stays low while a non-final burst is pending.

// File: rtl/bsplit_pkg.sv
// Package: shared types for the burst splitter.
// Assumes nothing beyond being compiled before the modules that import it.
package bsplit_pkg;

    // Sequencer occupancy state.
    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_BUSY = 1'b1
    } seq_state_e;

    // Direction encoding carried on each burst.
    localparam logic DIR_READ  = 1'b0;
    localparam logic DIR_WRITE = 1'b1;

endpackage

// File: rtl/bsplit_sizer.sv
// Module: bsplit_sizer
// Chooses the effective byte length of a transaction and turns it into a
// burst count rounded up. Assumes BURST_BYTES is a power of two no larger
// than 2**LEN_W.
module bsplit_sizer
    import bsplit_pkg::*;
#(
    parameter int LEN_W       = 16,
    parameter int BURST_BYTES = 256,
    localparam int SHIFT      = $clog2(BURST_BYTES),
    localparam int CNT_W      = LEN_W - SHIFT + 1
) (
    input  logic [LEN_W-1:0] len,
    input  logic             write,
    input  logic [LEN_W-1:0] cmd_len,
    output logic [CNT_W-1:0] count
);

    localparam logic [LEN_W:0] ROUND_UP = (LEN_W+1)'(BURST_BYTES - 1);

    logic [LEN_W-1:0] eff_len;
    logic [LEN_W:0]   padded;

    // Zero-byte read commands are sized by their separate request length.
    always_comb begin
        if (write == DIR_READ && len == '0) begin
            eff_len = cmd_len;
        end else begin
            eff_len = len;
        end
    end

    // Round up to whole bursts by adding burst-1 before the shift.
    always_comb begin
        padded = {1'b0, eff_len} + ROUND_UP;
        count  = padded[LEN_W:SHIFT];
    end

endmodule

// File: rtl/bsplit_chmap.sv
// Module: bsplit_chmap
// Maps a burst byte address to a pseudo-channel by taking the address bits
// just above the burst offset. Assumes both parameters are powers of two.
module bsplit_chmap #(
    parameter int ADDR_W      = 32,
    parameter int BURST_BYTES = 256,
    parameter int NUM_CH      = 8,
    localparam int SHIFT      = $clog2(BURST_BYTES),
    localparam int CH_W       = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [CH_W-1:0]   ch
);

    generate
        if (NUM_CH == 1) begin : g_single
            // A single channel takes every burst.
            always_comb ch = '0;
        end else begin : g_striped
            // Channel index sits directly above the burst offset bits.
            always_comb ch = addr[SHIFT +: CH_W];
        end
    endgenerate

endmodule

// File: rtl/bsplit_seq.sv
// Module: bsplit_seq
// Holds the transaction being split and steps the burst address and the
// remaining count on each handoff. A load has priority over a step, so a
// new transaction may replace the old one in the cycle its final burst
// leaves. Assumes count is nonzero whenever load is asserted.
module bsplit_seq
    import bsplit_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int CNT_W       = 9,
    parameter int TAG_W       = 4,
    parameter int BURST_BYTES = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] base,
    input  logic [CNT_W-1:0]  count,
    input  logic              write_in,
    input  logic [TAG_W-1:0]  tag_in,
    input  logic              take,
    output logic              busy,
    output logic [ADDR_W-1:0] addr,
    output logic              write_out,
    output logic [TAG_W-1:0]  tag_out,
    output logic              last
);

    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(BURST_BYTES);

    seq_state_e       state;
    logic [CNT_W-1:0] remain;

    // Load a new transaction or advance to the next burst on handoff.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= SEQ_IDLE;
            addr      <= '0;
            remain    <= '0;
            write_out <= DIR_READ;
            tag_out   <= '0;
        end else if (load) begin
            state     <= SEQ_BUSY;
            addr      <= base;
            remain    <= count;
            write_out <= write_in;
            tag_out   <= tag_in;
        end else if (take) begin
            if (remain == CNT_W'(1)) begin
                state <= SEQ_IDLE;
            end else begin
                addr   <= addr + STEP;
                remain <= remain - CNT_W'(1);
            end
        end
    end

    // Expose occupancy and the final-burst marker.
    always_comb begin
        busy = (state == SEQ_BUSY);
        last = busy && (remain == CNT_W'(1));
    end

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !take && !load) |=> (busy && $stable(addr) && $stable(tag_out)
                                      && $stable(write_out) && $stable(last))); // R8

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !last && !load) |=> (busy && addr == $past(addr) + STEP)); // R3

    AST_LAST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (take && last && !load) |=> !busy); // R2

endmodule

// File: rtl/burst_splitter.sv
// Module: burst_splitter (top)
// Accepts one transaction at a time and emits its bursts on a valid/ready
// stream, each with a pseudo-channel taken from its address. Assumes
// BURST_BYTES and NUM_CH are positive powers of two and that
// BURST_BYTES <= 2**LEN_W. req_ready depends combinationally on bst_ready.
module burst_splitter
    import bsplit_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int LEN_W       = 16,
    parameter int TAG_W       = 4,
    parameter int BURST_BYTES = 256,
    parameter int NUM_CH      = 8,
    localparam int SHIFT      = $clog2(BURST_BYTES),
    localparam int CNT_W      = LEN_W - SHIFT + 1,
    localparam int CH_W       = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    input  logic              req_write,
    input  logic [LEN_W-1:0]  req_cmd_len,
    input  logic [TAG_W-1:0]  req_tag,
    output logic              bst_valid,
    input  logic              bst_ready,
    output logic [ADDR_W-1:0] bst_addr,
    output logic [CH_W-1:0]   bst_ch,
    output logic              bst_write,
    output logic [TAG_W-1:0]  bst_tag,
    output logic              bst_last
);

    // Elaboration-time parameter check.
    initial begin
        AST_PARAM_POW2: assert (BURST_BYTES > 0 && (BURST_BYTES & (BURST_BYTES - 1)) == 0
                                && NUM_CH > 0 && (NUM_CH & (NUM_CH - 1)) == 0)
            else $fatal(1, "burst size and channel count must be powers of two"); // R4
    end

    logic [CNT_W-1:0] txn_count;
    logic             seq_busy;
    logic             accept;
    logic             load;
    logic             take;

    bsplit_sizer #(
        .LEN_W       (LEN_W),
        .BURST_BYTES (BURST_BYTES)
    ) sizer_i (
        .len     (req_len),
        .write   (req_write),
        .cmd_len (req_cmd_len),
        .count   (txn_count)
    );

    bsplit_seq #(
        .ADDR_W      (ADDR_W),
        .CNT_W       (CNT_W),
        .TAG_W       (TAG_W),
        .BURST_BYTES (BURST_BYTES)
    ) seq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .base      (req_addr),
        .count     (txn_count),
        .write_in  (req_write),
        .tag_in    (req_tag),
        .take      (take),
        .busy      (seq_busy),
        .addr      (bst_addr),
        .write_out (bst_write),
        .tag_out   (bst_tag),
        .last      (bst_last)
    );

    bsplit_chmap #(
        .ADDR_W      (ADDR_W),
        .BURST_BYTES (BURST_BYTES),
        .NUM_CH      (NUM_CH)
    ) chmap_i (
        .addr (bst_addr),
        .ch   (bst_ch)
    );

    // Handshakes: a new transaction may enter as the final burst leaves.
    always_comb begin
        bst_valid = seq_busy;
        take      = bst_valid && bst_ready;
        req_ready = !seq_busy || (take && bst_last);
        accept    = req_valid && req_ready;
        load      = accept && (txn_count != '0);
    end

    AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && bst_valid) |-> (bst_ready && bst_last)); // R9

    AST_ZERO_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && txn_count == '0) |=> !bst_valid); // R5

    AST_FIRST_BURST: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (bst_valid && bst_addr == $past(req_addr) && bst_tag == $past(req_tag))); // R7

endmodule

// File: tb/burst_splitter_tb_top.sv
// Bench: vector table walked by one loop, then directed reset and
// back-to-back cases. Defaults: 256-byte bursts, 8 channels.
module burst_splitter_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic [15:0] req_len = '0;
    logic        req_write = 1'b0;
    logic [15:0] req_cmd_len = '0;
    logic [3:0]  req_tag = '0;
    logic        bst_valid;
    logic        bst_ready = 1'b0;
    logic [31:0] bst_addr;
    logic [2:0]  bst_ch;
    logic        bst_write;
    logic [3:0]  bst_tag;
    logic        bst_last;

    int n_tests = 0;
    int n_fail  = 0;
    int k       = 0;

    always #5 clk = ~clk;

    burst_splitter dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_len(req_len), .req_write(req_write), .req_cmd_len(req_cmd_len),
        .req_tag(req_tag),
        .bst_valid(bst_valid), .bst_ready(bst_ready), .bst_addr(bst_addr),
        .bst_ch(bst_ch), .bst_write(bst_write), .bst_tag(bst_tag),
        .bst_last(bst_last)
    );

    typedef struct packed {
        logic [31:0] addr;
        logic [15:0] len;
        logic        wr;
        logic [15:0] cmd;
        logic [3:0]  tag;
        logic [8:0]  cnt;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{32'h0000_0000, 16'd256,  1'b1, 16'd0,   4'h1, 9'd1}, // R2 one burst
        '{32'h0000_0100, 16'd1024, 1'b0, 16'd0,   4'h2, 9'd4}, // R4 ch 1..4
        '{32'h0000_0700, 16'd513,  1'b1, 16'd0,   4'h3, 9'd3}, // R4 wrap 7,0,1
        '{32'h0000_1000, 16'd0,    1'b0, 16'd300, 4'h4, 9'd2}, // R6 read cmd len
        '{32'h0000_2000, 16'd0,    1'b1, 16'd300, 4'h5, 9'd0}, // R6 write ignores
        '{32'h0000_0080, 16'd256,  1'b0, 16'd0,   4'h6, 9'd1}, // R3 unaligned
        '{32'h0000_3F00, 16'd2048, 1'b0, 16'd77,  4'h7, 9'd8}, // R6 cmd ignored
        '{32'h0000_0000, 16'd0,    1'b0, 16'd0,   4'h8, 9'd0}, // R5 zero read
        '{32'hFFFF_FF00, 16'd1,    1'b1, 16'd0,   4'h9, 9'd1}  // R3 top address
    };

    task automatic check(string req, string what, longint act, longint exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    // Offer one transaction, then consume and check its bursts.
    task automatic run_vec(vec_t v);
        int got = 0;
        bit stall = 1'b0;
        logic [31:0] prev = '0;
        logic [31:0] ea;
        @(negedge clk);
        req_addr = v.addr; req_len = v.len; req_write = v.wr;
        req_cmd_len = v.cmd; req_tag = v.tag; req_valid = 1'b1; bst_ready = 1'b0;
        #1 check("R9", "ready when idle", req_ready, 1);
        for (int c = 0; c < 100; c++) begin
            @(negedge clk);
            req_valid = 1'b0;
            bst_ready = (k % 3) != 1;
            k++;
            #1;
            if (v.cnt == 0) begin
                check("R5", "no burst for zero length", bst_valid, 0);
                break;
            end
            if (stall) check("R8", "addr held on stall", bst_addr, prev);
            stall = bst_valid && !bst_ready;
            prev  = bst_addr;
            if (bst_valid && bst_ready) begin
                ea = v.addr + 32'(got) * 32'd256;
                check("R3", "burst address", bst_addr, ea);
                check("R4", "channel", bst_ch, ea[10:8]);
                check("R2", "last flag", bst_last, (got == int'(v.cnt) - 1));
                check("R7", "direction", bst_write, v.wr);
                check("R7", "tag", bst_tag, v.tag);
                got++;
                if (got == int'(v.cnt)) break;
            end
        end
        check("R2", "burst count", got, v.cnt);
        @(negedge clk);
        bst_ready = 1'b0;
        #1 check("R2", "idle after final", bst_valid, 0);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL R1 watchdog actual=1 expected=0");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1", "ready after reset", req_ready, 1);
        check("R1", "no burst after reset", bst_valid, 0);

        for (int i = 0; i < NV; i++) run_vec(VECS[i]);

        // R9: final handoff and next accept in the same cycle.
        @(negedge clk);
        req_addr = 32'h500; req_len = 16'd512; req_write = 1'b1;
        req_cmd_len = '0; req_tag = 4'h3; req_valid = 1'b1; bst_ready = 1'b0;
        @(negedge clk);
        req_valid = 1'b0; bst_ready = 1'b1;
        #1 check("R9", "busy blocks accept", req_ready, 0);
        check("R3", "first of pair", bst_addr, 32'h500);
        @(negedge clk);
        req_addr = 32'h4000; req_len = 16'd256; req_write = 1'b0;
        req_tag = 4'h9; req_valid = 1'b1; bst_ready = 1'b1;
        #1 check("R9", "final burst is last", bst_last, 1);
        check("R9", "ready on final handoff", req_ready, 1);
        @(negedge clk);
        req_valid = 1'b0; bst_ready = 1'b0;
        #1 check("R9", "next valid", bst_valid, 1);
        check("R9", "next address", bst_addr, 32'h4000);
        check("R9", "next tag", bst_tag, 4'h9);
        check("R4", "next channel", bst_ch, 0);
        @(negedge clk);
        bst_ready = 1'b1;
        @(negedge clk);
        bst_ready = 1'b0;
        #1 check("R2", "idle after pair", bst_valid, 0);

        // R1: reset in the middle of a transaction.
        @(negedge clk);
        req_addr = '0; req_len = 16'd1024; req_write = 1'b0; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        #1 check("R1", "busy before reset", bst_valid, 1);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        #1 check("R1", "reset clears burst", bst_valid, 0);
        check("R1", "reset restores ready", req_ready, 1);

        summary();
        $finish;
    end

endmodule